// File: doc/BRIEF.md
# Transmit Slot Ownership Tracker

This block arbitrates the ownership of a small set of transmit buffer slots that a producer CPU fills and a consumer CPU transmits from. With two slots the producer can prepare the next packet in one slot while the consumer sends from the other. The producer hands a slot over with a ready event. The consumer takes the slot into transmission with an accept event and returns it with a done event. Each event is a one-cycle strobe tagged with a slot index.

For each slot the tracker holds a state: free, queued or in flight. From that state it drives two ownership bits, one saying the producer may write the slot and one saying the consumer may. Handed-over slot indices enter a small queue, so the consumer sees the oldest readied slot first and must accept slots in that order. Only one slot may be in flight at a time.

Events that break the protocol are flagged. So are write attempts that a side reports on its write-monitor inputs for a slot it does not own. Each such violation sets a sticky per-slot flag and raises an interrupt. The flags are cleared by a write-one-to-clear input. A violating event never changes slot state or the queue.

Top module: `bufown_tracker`

## Requirements
- R1: After reset every slot is free (slot_state code 0), the producer owns every slot, the consumer owns none, head_valid is 0, and viol_flags and viol_irq are 0. slot_state bits [2s+1:2s] carry slot s with codes 0 = free, 1 = queued, 2 = in flight.
- R2: A ready event on a free slot makes that slot queued. From the next cycle on, the producer loses write ownership of the slot (prod_own bit s low) and the consumer gains it (cons_own bit s high).
- R3: Slots made queued enter an in-order queue. head_valid and head_idx present the oldest queued slot not yet accepted, and present the next one after that slot is accepted.
- R4: An accept event is legal only when the slot is queued, is at the head of the queue, and no other slot is in flight. A legal accept makes the slot in flight and removes it from the queue. At most one slot is in flight at any time.
- R5: An accept event that is not legal under R4 sets that slot's violation flag and leaves every slot state and the queue unchanged.
- R6: A done event on the in-flight slot makes it free. A done event on a slot that is not in flight sets that slot's flag with no state change. A done on the in-flight slot and a legal accept on the other slot in the same cycle both take effect.
- R7: A ready event on a slot that is not free sets that slot's flag and changes neither the state nor the queue.
- R8: A producer write strobe on a slot that is not free, or a consumer write strobe on a free slot, sets that slot's flag. Writes by the owning side set nothing.
- R9: Violation flags are sticky, one per slot. viol_irq is high while any flag is set. A 1 in viol_clr bit s clears flag s, but a new violation on slot s in the same cycle keeps the flag set.
- R10: Every output reflects the events of a cycle from the following clock cycle on (with the default combinational interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_stb | input | 1 | Producer hands a slot over |
| ready_idx | input | IDX_W | Slot of the ready event |
| accept_stb | input | 1 | Consumer starts sending a slot |
| accept_idx | input | IDX_W | Slot of the accept event |
| done_stb | input | 1 | Consumer finished sending a slot |
| done_idx | input | IDX_W | Slot of the done event |
| prod_wr_stb | input | 1 | Producer write attempt monitor |
| prod_wr_idx | input | IDX_W | Slot of the producer write |
| cons_wr_stb | input | 1 | Consumer write attempt monitor |
| cons_wr_idx | input | IDX_W | Slot of the consumer write |
| viol_clr | input | NUM_SLOTS | Write-one-to-clear of violation flags |
| slot_state | output | 2*NUM_SLOTS | Per-slot state codes |
| prod_own | output | NUM_SLOTS | Producer may write slot |
| cons_own | output | NUM_SLOTS | Consumer may write slot |
| head_valid | output | 1 | A queued slot awaits acceptance |
| head_idx | output | IDX_W | Oldest queued slot |
| viol_flags | output | NUM_SLOTS | Sticky per-slot violation flags |
| viol_irq | output | 1 | Violation interrupt |

## Verification
The bench builds the block with its defaults: NUM_SLOTS = 2 and a combinational interrupt (IRQ_REG = 0). Two slots are enough to reach every ordering case: both slots queued in either order, an out-of-order accept, a second accept while the other slot is in flight, and a done on one slot paired with an accept on the other in the same cycle. Long random runs of overlapping strobes and clears bring in events colliding in a single cycle, such as a clear racing a new violation. These runs are compared every cycle against a bench model of slot states, queue order and flags.

// File: rtl/bufown_pkg.sv
package bufown_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE     = 2'd0,
      SLOT_QUEUED   = 2'd1,
      SLOT_INFLIGHT = 2'd2
   } slot_st_e;

   typedef struct packed {
      logic rdy;
      logic acc;
      logic done;
      logic pwr;
      logic cwr;
   } slot_ev_t;

endpackage

// File: rtl/bufown_decode.sv
module bufown_decode #(
   parameter int NUM_SLOTS = 2,
   parameter int IDX_W     = 1
) (
   input  logic                 stb,
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_SLOTS-1:0] hit
);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
      assign hit[s] = stb && (idx == IDX_W'(s));
   end

endmodule

// File: rtl/bufown_fifo.sv
module bufown_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         valid,
   output logic [W-1:0] head
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] wr_ptr;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= nxt(wr_ptr);
         end
         if (pop) begin
            rd_ptr <= nxt(rd_ptr);
         end
         if (push && !pop) begin
            cnt <= cnt + 1'b1;
         end else if (pop && !push) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign valid = (cnt != '0);
   assign head  = mem[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt == CW'(DEPTH)) |-> pop);  // R3

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt != '0));  // R4

endmodule

// File: rtl/bufown_slot.sv
module bufown_slot
   import bufown_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  slot_ev_t ev,
   input  logic     acc_grant,
   output slot_st_e st,
   output logic     rdy_ok,
   output logic     acc_ok,
   output logic     done_ok,
   output logic     viol
);

   logic bad_rdy;
   logic bad_acc;
   logic bad_done;
   logic bad_pwr;
   logic bad_cwr;

   assign rdy_ok   = ev.rdy  && (st == SLOT_FREE);
   assign acc_ok   = ev.acc  && (st == SLOT_QUEUED) && acc_grant;
   assign done_ok  = ev.done && (st == SLOT_INFLIGHT);

   assign bad_rdy  = ev.rdy  && (st != SLOT_FREE);
   assign bad_acc  = ev.acc  && !((st == SLOT_QUEUED) && acc_grant);
   assign bad_done = ev.done && (st != SLOT_INFLIGHT);
   assign bad_pwr  = ev.pwr  && (st != SLOT_FREE);
   assign bad_cwr  = ev.cwr  && (st == SLOT_FREE);
   assign viol     = bad_rdy | bad_acc | bad_done | bad_pwr | bad_cwr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SLOT_FREE;
      end else if (rdy_ok) begin
         st <= SLOT_QUEUED;
      end else if (acc_ok) begin
         st <= SLOT_INFLIGHT;
      end else if (done_ok) begin
         st <= SLOT_FREE;
      end
   end

   AST_FREE_NOT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SLOT_FREE) |=> (st != SLOT_INFLIGHT));  // R4

   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> (st == SLOT_FREE));  // R6

   AST_BAD_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rdy && st == SLOT_QUEUED) |=> (st != SLOT_FREE));  // R7

endmodule

// File: rtl/bufown_viol.sv
module bufown_viol #(
   parameter int NUM_SLOTS = 2,
   parameter int IRQ_REG   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] set,
   input  logic [NUM_SLOTS-1:0] clr,
   output logic [NUM_SLOTS-1:0] flags,
   output logic                 irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flags & ~clr) | set;
      end
   end

   if (IRQ_REG != 0) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq <= 1'b0;
         end else begin
            irq <= |flags;
         end
      end
   end else begin : g_irq_comb
      assign irq = |flags;
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[s] && !clr[s]) |=> flags[s]);  // R9
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[s] |=> flags[s]);  // R9
   end

endmodule

// File: rtl/bufown_tracker.sv
module bufown_tracker
   import bufown_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int IRQ_REG   = 0,
   parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ready_stb,
   input  logic [IDX_W-1:0]       ready_idx,
   input  logic                   accept_stb,
   input  logic [IDX_W-1:0]       accept_idx,
   input  logic                   done_stb,
   input  logic [IDX_W-1:0]       done_idx,
   input  logic                   prod_wr_stb,
   input  logic [IDX_W-1:0]       prod_wr_idx,
   input  logic                   cons_wr_stb,
   input  logic [IDX_W-1:0]       cons_wr_idx,
   input  logic [NUM_SLOTS-1:0]   viol_clr,
   output logic [2*NUM_SLOTS-1:0] slot_state,
   output logic [NUM_SLOTS-1:0]   prod_own,
   output logic [NUM_SLOTS-1:0]   cons_own,
   output logic                   head_valid,
   output logic [IDX_W-1:0]       head_idx,
   output logic [NUM_SLOTS-1:0]   viol_flags,
   output logic                   viol_irq
);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("bufown_tracker: NUM_SLOTS must be at least 2");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("bufown_tracker: IRQ_REG must be 0 or 1");
   end
   if ((1 << IDX_W) < NUM_SLOTS) begin : g_bad_idx
      $error("bufown_tracker: IDX_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0] hit_rdy;
   logic [NUM_SLOTS-1:0] hit_acc;
   logic [NUM_SLOTS-1:0] hit_done;
   logic [NUM_SLOTS-1:0] hit_pwr;
   logic [NUM_SLOTS-1:0] hit_cwr;

   bufown_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_rdy (
      .stb(ready_stb), .idx(ready_idx), .hit(hit_rdy));
   bufown_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_acc (
      .stb(accept_stb), .idx(accept_idx), .hit(hit_acc));
   bufown_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_done (
      .stb(done_stb), .idx(done_idx), .hit(hit_done));
   bufown_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_pwr (
      .stb(prod_wr_stb), .idx(prod_wr_idx), .hit(hit_pwr));
   bufown_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dec_cwr (
      .stb(cons_wr_stb), .idx(cons_wr_idx), .hit(hit_cwr));

   slot_st_e             st [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] inflight;
   logic [NUM_SLOTS-1:0] rdy_ok;
   logic [NUM_SLOTS-1:0] acc_ok;
   logic [NUM_SLOTS-1:0] done_ok;
   logic [NUM_SLOTS-1:0] acc_grant;
   logic [NUM_SLOTS-1:0] viol_set;

   logic                 q_push;
   logic                 q_pop;
   logic [IDX_W-1:0]     q_push_idx;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [NUM_SLOTS-1:0] busy_others;
      slot_ev_t             ev;

      // A slot finishing this cycle no longer blocks an accept elsewhere.
      always_comb begin
         busy_others    = inflight & ~done_ok;
         busy_others[s] = 1'b0;
      end

      assign acc_grant[s] = head_valid && (head_idx == IDX_W'(s))
                            && (busy_others == '0);

      assign ev = '{rdy:  hit_rdy[s],  acc: hit_acc[s], done: hit_done[s],
                    pwr:  hit_pwr[s],  cwr: hit_cwr[s]};

      bufown_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .ev        (ev),
         .acc_grant (acc_grant[s]),
         .st        (st[s]),
         .rdy_ok    (rdy_ok[s]),
         .acc_ok    (acc_ok[s]),
         .done_ok   (done_ok[s]),
         .viol      (viol_set[s])
      );

      assign inflight[s]          = (st[s] == SLOT_INFLIGHT);
      assign slot_state[2*s +: 2] = st[s];
      assign prod_own[s]          = (st[s] == SLOT_FREE);
      assign cons_own[s]          = (st[s] != SLOT_FREE);
   end

   always_comb begin
      q_push_idx = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (rdy_ok[s]) begin
            q_push_idx = IDX_W'(s);
         end
      end
   end

   assign q_push = |rdy_ok;
   assign q_pop  = |acc_ok;

   bufown_fifo #(.DEPTH(NUM_SLOTS), .W(IDX_W)) u_order_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (q_push_idx),
      .pop       (q_pop),
      .valid     (head_valid),
      .head      (head_idx)
   );

   bufown_viol #(.NUM_SLOTS(NUM_SLOTS), .IRQ_REG(IRQ_REG)) u_viol (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (viol_set),
      .clr   (viol_clr),
      .flags (viol_flags),
      .irq   (viol_irq)
   );

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(inflight) <= 1);  // R4

   AST_POP_IS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |-> head_valid);  // R3

   AST_OWNERSHIP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_own & cons_own) == '0);  // R2

endmodule

// File: tb/test_bufown_tracker.sv
module test_bufown_tracker;

   localparam int NS = 2;
   localparam int IW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ready_stb = 1'b0, accept_stb = 1'b0, done_stb = 1'b0;
   logic          prod_wr_stb = 1'b0, cons_wr_stb = 1'b0;
   logic [IW-1:0] ready_idx = '0, accept_idx = '0, done_idx = '0;
   logic [IW-1:0] prod_wr_idx = '0, cons_wr_idx = '0;
   logic [NS-1:0] viol_clr = '0;
   logic [2*NS-1:0] slot_state;
   logic [NS-1:0] prod_own, cons_own, viol_flags;
   logic          head_valid, viol_irq;
   logic [IW-1:0] head_idx;

   int checks = 0;
   int fails  = 0;

   int      mst [NS];
   int      mq  [NS];
   int      mqn;
   bit [NS-1:0] mflags;

   always #2 clk = ~clk;  // 250 MHz

   bufown_tracker #(.NUM_SLOTS(NS)) i_bufown_tracker (
      .clk(clk), .rst_n(rst_n),
      .ready_stb(ready_stb), .ready_idx(ready_idx),
      .accept_stb(accept_stb), .accept_idx(accept_idx),
      .done_stb(done_stb), .done_idx(done_idx),
      .prod_wr_stb(prod_wr_stb), .prod_wr_idx(prod_wr_idx),
      .cons_wr_stb(cons_wr_stb), .cons_wr_idx(cons_wr_idx),
      .viol_clr(viol_clr), .slot_state(slot_state),
      .prod_own(prod_own), .cons_own(cons_own),
      .head_valid(head_valid), .head_idx(head_idx),
      .viol_flags(viol_flags), .viol_irq(viol_irq));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   // Compare every output with the model state.
   task automatic compare(input string tag);
      for (int s = 0; s < NS; s++) begin
         chk(tag, $sformatf("state slot%0d", s), int'(slot_state[2*s +: 2]), mst[s]);
         chk(tag, $sformatf("prod_own slot%0d", s), int'(prod_own[s]), int'(mst[s] == 0));
         chk(tag, $sformatf("cons_own slot%0d", s), int'(cons_own[s]), int'(mst[s] != 0));
      end
      chk(tag, "head_valid", int'(head_valid), int'(mqn > 0));
      if (mqn > 0) chk(tag, "head_idx", int'(head_idx), mq[0]);
      chk(tag, "viol_flags", int'(viol_flags), int'(mflags));
      chk(tag, "viol_irq", int'(viol_irq), int'(mflags != 0));
   endtask

   // Model of the requirements, advanced once per clock.
   task automatic model_step(input bit r, input int ri, input bit a, input int ai,
                             input bit d, input int di, input bit pw, input int pwi,
                             input bit cw, input int cwi, input bit [NS-1:0] clr);
      bit [NS-1:0] v = '0;
      bit done_ok, acc_ok, rdy_ok, busy;
      done_ok = d && mst[di] == 2;
      busy = 1'b0;
      for (int j = 0; j < NS; j++)
         if (j != ai && mst[j] == 2 && !(done_ok && di == j)) busy = 1'b1;
      acc_ok = a && mst[ai] == 1 && mqn > 0 && mq[0] == ai && !busy;
      rdy_ok = r && mst[ri] == 0;
      if (r && !rdy_ok) v[ri] = 1'b1;
      if (a && !acc_ok) v[ai] = 1'b1;
      if (d && !done_ok) v[di] = 1'b1;
      if (pw && mst[pwi] != 0) v[pwi] = 1'b1;
      if (cw && mst[cwi] == 0) v[cwi] = 1'b1;
      if (rdy_ok) mst[ri] = 1;
      if (acc_ok) mst[ai] = 2;
      if (done_ok) mst[di] = 0;
      if (acc_ok) begin
         for (int k = 0; k < NS - 1; k++) mq[k] = mq[k+1];
         mqn--;
      end
      if (rdy_ok) begin
         mq[mqn] = ri;
         mqn++;
      end
      mflags = (mflags & ~clr) | v;
   endtask

   task automatic cyc(input bit r, input int ri, input bit a, input int ai,
                      input bit d, input int di, input bit pw, input int pwi,
                      input bit cw, input int cwi, input bit [NS-1:0] clr,
                      input string tag);
      ready_stb = r;   ready_idx = IW'(ri);
      accept_stb = a;  accept_idx = IW'(ai);
      done_stb = d;    done_idx = IW'(di);
      prod_wr_stb = pw; prod_wr_idx = IW'(pwi);
      cons_wr_stb = cw; cons_wr_idx = IW'(cwi);
      viol_clr = clr;
      model_step(r, ri, a, ai, d, di, pw, pwi, cw, cwi, clr);
      @(posedge clk);
      @(negedge clk);
      ready_stb = 0; accept_stb = 0; done_stb = 0;
      prod_wr_stb = 0; cons_wr_stb = 0; viol_clr = '0;
      compare(tag);
   endtask

   task automatic rd(input int i, input string t);    cyc(1,i,0,0,0,0,0,0,0,0,'0,t); endtask
   task automatic ac(input int i, input string t);    cyc(0,0,1,i,0,0,0,0,0,0,'0,t); endtask
   task automatic dn(input int i, input string t);    cyc(0,0,0,0,1,i,0,0,0,0,'0,t); endtask
   task automatic clear(input bit [NS-1:0] c, input string t); cyc(0,0,0,0,0,0,0,0,0,0,c,t); endtask

   initial begin
      for (int s = 0; s < NS; s++) begin mst[s] = 0; mq[s] = 0; end
      mqn = 0; mflags = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1");  // reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      ac(0, "R5");                    // accept with nothing pending
      clear(2'b01, "R9");             // write-one-to-clear
      rd(1, "R2");                    // slot 1 handed over
      rd(0, "R3");                    // head stays slot 1
      cyc(0,0,0,0,0,0,1,1,0,0,'0,"R8");   // producer writes queued slot
      cyc(0,0,0,0,0,0,0,0,1,0,'0,"R8");   // consumer writes queued slot: allowed
      clear(2'b10, "R9");
      rd(1, "R7");                    // ready on a queued slot
      ac(0, "R5");                    // not at head
      ac(1, "R4");                    // head accepted
      ac(0, "R5");                    // other slot in flight
      clear(2'b11, "R9");
      cyc(0,0,1,0,1,1,0,0,0,0,'0,"R6");   // done 1 and accept 0 together
      dn(1, "R6");                    // done on a free slot
      rd(0, "R7");                    // ready on the in-flight slot
      cyc(0,0,0,0,0,0,0,0,1,1,2'b01,"R8"); // consumer writes free slot 1
      cyc(0,0,0,0,0,0,1,0,0,0,2'b01,"R9"); // clear races a new violation
      dn(0, "R6");
      clear(2'b11, "R10");

      void'($urandom(32'h0005_eed5));
      for (int n = 0; n < 4000; n++) begin
         bit r  = ($urandom % 100) < 35;
         bit a  = ($urandom % 100) < 35;
         bit d  = ($urandom % 100) < 30;
         bit pw = ($urandom % 100) < 10;
         bit cw = ($urandom % 100) < 10;
         bit [NS-1:0] c = (($urandom % 100) < 25) ? NS'($urandom) : '0;
         cyc(r, $urandom % NS, a, $urandom % NS, d, $urandom % NS,
             pw, $urandom % NS, cw, $urandom % NS, c, "R10");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule